// File: doc/BRIEF.md
# Buffered I2C Transaction Engine

This block is an I2C bus master that carries out a complete transaction from a small byte buffer. Software does not toggle any bus lines. It fills the buffer with the address byte and any outgoing bytes, then writes one control byte. That byte holds a start flag and the total byte count, address byte included. The engine then issues a START condition and shifts the counted bytes out, or shifts them in. It closes with a STOP condition and posts the outcome in a status byte.

Buffer byte 0 always holds the 7-bit slave address in bits 7:1 and the direction in bit 0 (1 = read). In a write, bytes 1 and upward are sent in order. In a read, the bytes received from the slave are stored back into bytes 1 and upward. Both lines are open-drain. The block only ever pulls SCL or SDA low, or lets go of them. The SCL rate comes from a parameterised divider. Clock stretching and multi-master arbitration are not handled.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the status byte reads 0x00 and neither SCL nor SDA is pulled low.
- R2: Register address 0 is the control byte and address 1 is the status byte, which is read-only. Address 2+k is buffer byte k for k below DEPTH, and it can be written and read back while the engine is not busy.
- R3: A control write with bit 7 = 1 starts a transaction. Bits 6:0 give the byte count, address byte included. The write is acted on only when the count is between 1 and DEPTH. A count of 0 or above DEPTH produces no bus activity and leaves the status unchanged.
- R4: From the cycle after an accepted start until the STOP completes, status bits 7:6 read 10. During that time, further start commands and host writes to buffer bytes have no effect.
- R5: A transaction opens with exactly one START and closes with exactly one STOP. Each byte goes out MSB first. In a write, buffer bytes 0 to count-1 are sent in order and each is followed by an acknowledge slot.
- R6: A transaction that completes without a NACK leaves status 0x40 (bits 7:6 = 01).
- R7: When buffer byte 0 has bit 0 = 1, the bytes received after the address are stored at buffer bytes 1 to count-1. The master acknowledges each received byte except the last, which it NACKs before STOP. Buffer byte 0 is left unchanged.
- R8: A NACK on any byte the master sends (the address or a write byte) ends the transfer with STOP at once. No further bytes are sent and the status becomes 0xC0 (bits 7:6 = 11).
- R9: A control write with bit 7 = 0 returns the engine to idle in the next cycle, even mid-transfer. Status reads 0x00 and both lines are released.
- R10: Every SCL rising edge within a transaction follows the previous one by 4*Q clock cycles, where Q = max(1, CLK_HZ/(4*SCL_HZ)). SDA changes while SCL is high only for START and STOP.
- R11: With the default DEPTH of 64, a single 50-byte write command (address plus 49 bytes) is carried out in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 status, 2+k buffer byte k) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that SCL rises whenever the master releases it, so no slave stretches the clock. They also assume that the sensed SDA is simply the wired-AND of master and slave. The bench slave model never touches SCL. It changes its SDA pull only right after a falling SCL edge, and it is told the transfer length so that it does not drive the line past the last acknowledge slot. The bench issues start commands during a busy transfer, and a mid-transfer abort, only in the dedicated tests for R4 and R9.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  typedef enum logic [1:0] {
    STAT_IDLE = 2'b00,
    STAT_DONE = 2'b01,
    STAT_BUSY = 2'b10,
    STAT_NACK = 2'b11
  } stat_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_START = 2'b01,
    PH_BIT   = 2'b10,
    PH_STOP  = 2'b11
  } phase_e;

  // quarter of one SCL period, in system clock cycles
  function automatic int unsigned quarter_cycles(input int unsigned clk_hz,
                                                 input int unsigned scl_hz);
    int unsigned q;
    q = clk_hz / (4 * scl_hz);
    return (q < 1) ? 1 : q;
  endfunction

  function automatic logic [6:0] cmd_count(input logic [7:0] cmd);
    return cmd[6:0];
  endfunction

  function automatic logic count_ok(input logic [6:0] cnt, input int unsigned depth);
    return (cnt != 7'd0) && (int'(cnt) <= int'(depth));
  endfunction

  // 1 = pull SCL low
  function automatic logic scl_pull(input phase_e ph, input logic [1:0] q);
    case (ph)
      PH_START: return q == 2'd2;
      PH_BIT:   return (q == 2'd0) || (q == 2'd3);
      PH_STOP:  return q == 2'd0;
      default:  return 1'b0;
    endcase
  endfunction

  // 1 = pull SDA low
  function automatic logic sda_pull(input phase_e ph, input logic [1:0] q,
                                    input logic in_ack, input logic is_rx,
                                    input logic last, input logic msb);
    case (ph)
      PH_START: return q != 2'd0;
      PH_BIT: begin
        if (in_ack) return is_rx && !last;
        else        return !is_rx && !msb;
      end
      PH_STOP:  return q != 2'd2;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
  parameter int unsigned QUARTER = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  generate
    if (QUARTER <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(QUARTER);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt <= '0;
        else if (clr || cnt == CW'(QUARTER - 1)) cnt <= '0;
        else                                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(QUARTER - 1)) && !clr;

      p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/i2cb_bytebuf.sv
module i2cb_bytebuf #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [IW-1:0] h_idx,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic          e_we,
  input  logic [IW-1:0] e_widx,
  input  logic [7:0]    e_wdata,
  input  logic [IW-1:0] e_ridx,
  output logic [7:0]    e_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else begin
      if (h_we) mem[h_idx] <= h_wdata;
      if (e_we) mem[e_widx] <= e_wdata;
    end
  end

  assign h_rdata = mem[h_idx];
  assign e_rdata = mem[e_ridx];

  p_one_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_we && e_we));
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
  import i2cb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned NW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          go,
  input  logic [6:0]    go_count,
  input  logic          abort,
  input  logic          sda_i,
  input  logic [7:0]    buf_rdata,
  output logic [IW-1:0] ld_idx,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic [1:0]    status
);
  phase_e        phase;
  stat_e         stat;
  logic [1:0]    q;
  logic [3:0]    bit_idx;
  logic [NW-1:0] byte_idx;
  logic [NW-1:0] byte_cnt;
  logic [7:0]    shreg;
  logic          rd_mode;
  logic          ack_bit;
  logic          nack_seen;

  // named internal events
  logic in_ack, is_rx, last_byte, sample_now, bit_end, byte_end, nack_evt, rx_commit;
  assign in_ack     = (bit_idx == 4'd8);
  assign is_rx      = rd_mode && (byte_idx != '0);
  assign last_byte  = ((byte_idx + NW'(1)) == byte_cnt);
  assign sample_now = (phase == PH_BIT) && tick && (q == 2'd1);
  assign bit_end    = (phase == PH_BIT) && tick && (q == 2'd3);
  assign byte_end   = bit_end && in_ack;
  assign nack_evt   = byte_end && !is_rx && ack_bit;
  assign rx_commit  = byte_end && is_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      stat      <= STAT_IDLE;
      q         <= '0;
      bit_idx   <= '0;
      byte_idx  <= '0;
      byte_cnt  <= '0;
      shreg     <= '0;
      rd_mode   <= 1'b0;
      ack_bit   <= 1'b0;
      nack_seen <= 1'b0;
    end else if (abort) begin
      phase <= PH_IDLE;
      stat  <= STAT_IDLE;
      q     <= '0;
    end else if (go) begin
      phase     <= PH_START;
      stat      <= STAT_BUSY;
      q         <= '0;
      bit_idx   <= '0;
      byte_idx  <= '0;
      byte_cnt  <= NW'(go_count);
      nack_seen <= 1'b0;
    end else if (tick) begin
      case (phase)
        PH_START: begin
          if (q == 2'd2) begin
            phase   <= PH_BIT;
            q       <= '0;
            bit_idx <= '0;
            shreg   <= buf_rdata;
            rd_mode <= buf_rdata[0];
          end else begin
            q <= q + 2'd1;
          end
        end
        PH_BIT: begin
          q <= q + 2'd1;
          if (q == 2'd1) begin
            if (in_ack)     ack_bit <= sda_i;
            else if (is_rx) shreg   <= {shreg[6:0], sda_i};
          end
          if (q == 2'd3) begin
            if (!in_ack) begin
              bit_idx <= bit_idx + 4'd1;
              if (!is_rx) shreg <= {shreg[6:0], 1'b0};
            end else if (nack_evt) begin
              phase     <= PH_STOP;
              nack_seen <= 1'b1;
            end else if (last_byte) begin
              phase <= PH_STOP;
            end else begin
              byte_idx <= byte_idx + NW'(1);
              bit_idx  <= '0;
              shreg    <= buf_rdata;
            end
          end
        end
        PH_STOP: begin
          if (q == 2'd2) begin
            phase <= PH_IDLE;
            q     <= '0;
            stat  <= nack_seen ? STAT_NACK : STAT_DONE;
          end else begin
            q <= q + 2'd1;
          end
        end
        default: q <= '0;
      endcase
    end
  end

  assign ld_idx  = (phase == PH_START) ? '0 : IW'(byte_idx + NW'(1));
  assign wr_en   = rx_commit;
  assign wr_idx  = IW'(byte_idx);
  assign wr_data = shreg;
  assign scl_oe  = scl_pull(phase, q);
  assign sda_oe  = sda_pull(phase, q, in_ack, is_rx, last_byte, shreg[7]);
  assign busy    = (phase != PH_IDLE);
  assign status  = stat;

  p_sda_quiet_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BIT && $past(phase) == PH_BIT && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));
  p_busy_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (stat == STAT_BUSY));
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (!scl_oe && !sda_oe));
  p_nack_to_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_evt && !abort) |=> (phase == PH_STOP));
  p_index_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BIT) |-> (byte_idx < byte_cnt));
  p_end_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_STOP && phase == PH_IDLE && !$past(abort))
      |-> (stat == STAT_DONE || stat == STAT_NACK));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cb_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned SCL_HZ = 100_000,
  localparam int unsigned BUF_BASE = 2,
  localparam int unsigned ADDR_W   = $clog2(DEPTH + BUF_BASE),
  localparam int unsigned IW       = $clog2(DEPTH),
  localparam int unsigned QUARTER  = quarter_cycles(CLK_HZ, SCL_HZ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic [7:0]        ctrl_q;
  logic [ADDR_W-1:0] boff;
  logic              in_buf, ctrl_wr, go, abort, tick, busy;
  logic [1:0]        status;
  logic [IW-1:0]     ld_idx, wr_idx;
  logic              wr_en;
  logic [7:0]        wr_data, h_rdata, e_rdata;

  assign boff    = reg_addr - ADDR_W'(BUF_BASE);
  assign in_buf  = (reg_addr >= ADDR_W'(BUF_BASE)) && (int'(boff) < int'(DEPTH));
  assign ctrl_wr = reg_wr && (reg_addr == '0);
  assign abort   = ctrl_wr && !reg_wdata[7];
  assign go      = ctrl_wr && reg_wdata[7] && !busy && count_ok(cmd_count(reg_wdata), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(0))      reg_rdata = ctrl_q;
    else if (reg_addr == ADDR_W'(1)) reg_rdata = {status, 6'b0};
    else if (in_buf)                 reg_rdata = h_rdata;
  end

  i2cb_qtick #(.QUARTER(QUARTER)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(go), .tick(tick)
  );

  i2cb_bytebuf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .h_we(reg_wr && in_buf && !busy), .h_idx(IW'(boff)), .h_wdata(reg_wdata),
    .h_rdata(h_rdata),
    .e_we(wr_en), .e_widx(wr_idx), .e_wdata(wr_data),
    .e_ridx(ld_idx), .e_rdata(e_rdata)
  );

  i2cb_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .go(go), .go_count(cmd_count(reg_wdata)), .abort(abort),
    .sda_i(sda_i), .buf_rdata(e_rdata),
    .ld_idx(ld_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .status(status)
  );
endmodule

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;
  localparam int CLK_HZ = 8_000_000;
  localparam int SCL_HZ = 1_000_000;
  localparam int DEPTH  = 64;
  localparam int Q      = (CLK_HZ / (4 * SCL_HZ) < 1) ? 1 : CLK_HZ / (4 * SCL_HZ);
  localparam int AW     = $clog2(DEPTH + 2);
  localparam logic [6:0] SLV_ADDR = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_oe, sda_oe;
  logic slv_pull = 1'b0;
  wire  scl_bus = ~scl_oe;
  wire  sda_bus = ~(sda_oe | slv_pull);

  always #2 clk = ~clk;

  i2c_cmd_master #(.DEPTH(DEPTH), .CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int cyc = 0, n_start = 0, n_stop = 0;
  int last_rise = 0, gmin = 0, gmax = 0;
  bit gap_arm = 0;
  int slv_len = 1, slv_nack_at = -1, slv_rx_n = 0;
  logic [7:0] slv_rx [0:63];
  bit slv_mack [0:63];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] rd_byte(input int i);
    return 8'((i * 29 + 60) & 255);
  endfunction
  function automatic logic [7:0] wr_byte(input int i, input int n);
    return 8'((i * 53 + n * 7 + 1) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = 8'h80;
    for (int i = 0; i < 20000 && st[7:6] == 2'b10; i++) rd(1, st);
  endtask

  // bus monitors
  initial forever begin @(negedge sda_bus); if (scl_bus) n_start++; end
  initial forever begin @(posedge sda_bus); if (scl_bus) n_stop++; end
  initial forever begin
    @(posedge scl_bus);
    if (gap_arm) begin
      if (cyc - last_rise < gmin) gmin = cyc - last_rise;
      if (cyc - last_rise > gmax) gmax = cyc - last_rise;
    end
    last_rise = cyc; gap_arm = 1;
  end

  task automatic slv_recv(output logic [7:0] v);
    v = '0;
    for (int k = 0; k < 8; k++) begin @(posedge scl_bus); v = {v[6:0], sda_bus}; end
    @(negedge scl_bus);
  endtask

  task automatic slv_ack(input bit a);
    slv_pull = a;
    @(posedge scl_bus); @(negedge scl_bus);
    slv_pull = 1'b0;
  endtask

  // slave model: changes SDA only after SCL falls
  initial begin : slave_model
    logic [7:0] b, d;
    bit acked;
    forever begin
      forever begin @(negedge sda_bus); if (scl_bus) break; end
      slv_recv(b);
      slv_rx[0] = b; slv_rx_n = 1;
      acked = (b[7:1] == SLV_ADDR) && (slv_nack_at != 0);
      slv_ack(acked);
      if (acked && b[0]) begin
        for (int i = 1; i < slv_len; i++) begin
          d = rd_byte(i);
          for (int k = 7; k >= 0; k--) begin
            slv_pull = !d[k];
            @(posedge scl_bus); @(negedge scl_bus);
          end
          slv_pull = 1'b0;
          @(posedge scl_bus); slv_mack[i] = sda_bus;
          @(negedge scl_bus);
        end
      end else if (acked) begin
        for (int i = 1; i < slv_len; i++) begin
          slv_recv(b);
          slv_rx[i] = b; slv_rx_n++;
          acked = (i != slv_nack_at);
          slv_ack(acked);
          if (!acked) break;
        end
      end
    end
  end

  task automatic run_write(input int n, input logic [6:0] a7, input int nack_at,
                           input logic [7:0] exp_st, input int exp_rx);
    logic [7:0] st;
    int s0, p0;
    wr(0, 8'h00);
    wr(2, {a7, 1'b0});
    for (int i = 1; i < n; i++) wr(2 + i, wr_byte(i, n));
    slv_len = n; slv_nack_at = nack_at;
    s0 = n_start; p0 = n_stop;
    gap_arm = 0; gmin = 1 << 30; gmax = 0;
    wr(0, 8'h80 | 8'(n));
    rd(1, st);
    chk(st == 8'h80, "R4 busy status after start", st, 8'h80);
    wait_done(st);
    chk(st == exp_st, (exp_st == 8'h40) ? "R6 write done status" : "R8 nack status",
        st, exp_st);
    chk(slv_rx_n == exp_rx, "R8/R5 bytes seen by slave", slv_rx_n, exp_rx);
    chk(slv_rx[0] == {a7, 1'b0}, "R5 address byte", slv_rx[0], {a7, 1'b0});
    for (int i = 1; i < exp_rx; i++)
      chk(slv_rx[i] == wr_byte(i, n), "R5 payload byte", slv_rx[i], wr_byte(i, n));
    chk(n_start - s0 == 1, "R5 one START", n_start - s0, 1);
    chk(n_stop - p0 == 1, "R5 one STOP", n_stop - p0, 1);
  endtask

  task automatic run_read(input int n);
    logic [7:0] st, v;
    wr(0, 8'h00);
    wr(2, {SLV_ADDR, 1'b1});
    for (int i = 1; i < n; i++) wr(2 + i, 8'hFF);
    slv_len = n; slv_nack_at = -1;
    wr(0, 8'h80 | 8'(n));
    wait_done(st);
    chk(st == 8'h40, "R7 read done status", st, 8'h40);
    rd(2, v);
    chk(v == {SLV_ADDR, 1'b1}, "R7 address byte kept", v, {SLV_ADDR, 1'b1});
    for (int i = 1; i < n; i++) begin
      rd(2 + i, v);
      chk(v == rd_byte(i), "R7 received byte", v, rd_byte(i));
      chk(slv_mack[i] == (i == n - 1), "R7 master ack/nack", slv_mack[i], i == n - 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v, st;
    int s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rd(1, v);
    chk(v == 8'h00, "R1 reset status", v, 8'h00);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

    wr(2 + 5, 8'hA5); rd(2 + 5, v);
    chk(v == 8'hA5, "R2 buffer readback", v, 8'hA5);
    wr(0, 8'h00); rd(0, v);
    chk(v == 8'h00, "R2 control readback", v, 8'h00);

    s0 = n_start;
    wr(0, 8'h80); rd(1, v);
    chk(v == 8'h00, "R3 count 0 ignored", v, 8'h00);
    wr(0, 8'h80 | 8'(DEPTH + 1)); repeat (20) @(negedge clk); rd(1, v);
    chk(v == 8'h00, "R3 count above depth ignored", v, 8'h00);
    chk(n_start == s0, "R3 no START for bad count", n_start - s0, 0);

    for (int n = 1; n <= 6; n++) run_write(n, SLV_ADDR, -1, 8'h40, n);

    run_write(50, SLV_ADDR, -1, 8'h40, 50);
    chk(gmin == 4 * Q && gmax == 4 * Q, "R10/R11 SCL rise spacing", gmax, 4 * Q);

    for (int n = 1; n <= 5; n++) run_read(n);

    run_write(4, 7'h11, -1, 8'hC0, 1);
    run_write(5, SLV_ADDR, 2, 8'hC0, 3);
    wr(0, 8'h00); wr(2, {7'h11, 1'b1}); slv_len = 3; slv_nack_at = -1;
    wr(0, 8'h83); wait_done(st);
    chk(st == 8'hC0, "R8 read address nack", st, 8'hC0);

    // start and buffer writes during busy have no effect
    wr(0, 8'h00); wr(2, {SLV_ADDR, 1'b0});
    for (int i = 1; i < 4; i++) wr(2 + i, wr_byte(i, 4));
    slv_len = 4; slv_nack_at = -1;
    wr(0, 8'h84);
    wr(0, 8'h85);
    wr(3, 8'hEE);
    wait_done(st);
    chk(st == 8'h40, "R4 done after ignored start", st, 8'h40);
    chk(slv_rx_n == 4, "R4 second start ignored", slv_rx_n, 4);
    rd(3, v);
    chk(v == wr_byte(1, 4), "R4 buffer write ignored while busy", v, wr_byte(1, 4));

    wr(0, 8'h00); rd(1, v);
    chk(v == 8'h00, "R9 idle clears done", v, 8'h00);

    wr(2, {SLV_ADDR, 1'b0}); slv_len = 10;
    wr(0, 8'h8A);
    repeat (40) @(negedge clk);
    wr(0, 8'h00); rd(1, v);
    chk(v == 8'h00, "R9 abort status", v, 8'h00);
    chk(!scl_oe && !sda_oe, "R9 abort releases lines", {scl_oe, sda_oe}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule